// File: doc/BRIEF.md
# SD Data Buffer Status Controller

This block sits between a host register port and the data engine of an SD card host. It holds a small word buffer that both sides share. In the write direction the host fills the buffer and the engine drains it. In the read direction the engine fills it and the host drains it. The host moves all data through a single 32-bit data port. Two size registers, block length and block count, set the transfer size, and a read-only register returns their product as a byte total. A read-timeout register holds the value the engine uses for its data timeout.

The status word reports several things:
- live buffer readiness;
- sticky completion events and data-phase errors;
- sticky buffer misuse flags;
- a 2-bit code that classifies a failed write CRC handshake.

Sticky bits clear when the host writes 1 to them, so writing back a value just read clears exactly the bits that were seen. A fixed error summary over the error bits drives the `err_any` output.

Register addresses on `reg_addr`: 0 status, 1 block length, 2 block count, 3 read timeout, 4 data port, 5 transfer byte total.

Top module: `sdbuf_stat_ctrl`

## Requirements
- R1: Reset state. After reset, and two clock edges after `rst_n` rises:
  - status reads 0x0000_0040 (buffer empty, so only write-ready is set);
  - the read-timeout register reads 0x2DB4;
  - block length and block count read 0.
- R2: Block length (address 1) and block count (address 2) are writable and read back. Address 5 reads block count times block length.
- R3: The buffer is first-in first-out in both directions. With `dir_wr`=1, host writes to address 4 appear in order on `eng_rdata` as the engine pops them. With `dir_wr`=0, words pushed by the engine are returned in order by host reads of address 4.
- R4: Status bit 7 (read-ready) is 1 exactly when the buffer holds at least one word. Status bit 6 (write-ready) is 1 exactly when the buffer has a free slot. Host writes to bits 6 and 7 have no effect.
- R5: An `ev_rd_done` pulse sets status bit 11. An `ev_wr_done` pulse sets status bit 12.
- R6: Each of the following pulses sets its own status bit:

  | Pulse | Status bit |
  |---|---|
  | `ev_rd_timeout` | 0 |
  | `ev_rsp_timeout` | 1 |
  | `ev_rd_crc` | 3 |
  | `ev_rsp_crc` | 5 |

- R7: A write CRC report (`ev_wcrc_valid`) with a nonzero code does two things: it sets status bit 2, and it latches the code into status bits [10:9].
  - Code 2 means the card gave no CRC answer; it drives `wr_no_resp` high while bit 2 is set.
  - A report with code 0 changes nothing.
  - Clearing bit 2 also clears the code field.
- R8: Writing 1 to a sticky status bit clears it, and writing 0 leaves it. When an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R9: `err_any` is 1 exactly when any status bit selected by the mask 0x2F (bits 0, 1, 2, 3 and 5) is set. Bits 11 and 12 do not raise it.
- R10: Misuse of the data port sets a sticky flag and leaves the buffer contents unchanged:
  - a host data write while the buffer is full (`dir_wr`=1) sets bit 24 and the word is dropped;
  - a host data read while the buffer is empty (`dir_wr`=0) sets bit 25 and returns 0.
- R11: Host data-port accesses against the current direction are ignored. A read with `dir_wr`=1 returns 0, and a write with `dir_wr`=0 stores nothing. Neither access raises a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (pops the data port) |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, valid in the cycle of the address |
| dir_wr | input | 1 | Transfer direction: 1 host-to-card, 0 card-to-host |
| eng_push | input | 1 | Engine pushes a received word (read direction) |
| eng_wdata | input | 32 | Word pushed by the engine |
| eng_pop | input | 1 | Engine takes the head word (write direction) |
| eng_rdata | output | 32 | Head word of the buffer |
| eng_has_data | output | 1 | Buffer not empty |
| eng_has_space | output | 1 | Buffer not full |
| ev_rd_done | input | 1 | Read or data transfer complete pulse |
| ev_wr_done | input | 1 | Write operation complete pulse |
| ev_rd_timeout | input | 1 | Read data timeout pulse |
| ev_rd_crc | input | 1 | Read data CRC mismatch pulse |
| ev_rsp_timeout | input | 1 | Response timeout pulse |
| ev_rsp_crc | input | 1 | Response CRC mismatch pulse |
| ev_wcrc_valid | input | 1 | Write CRC handshake report strobe |
| ev_wcrc_code | input | 2 | Write CRC handshake code, 0 means success |
| blk_len_o | output | 12 | Block length register |
| blk_cnt_o | output | 16 | Block count register |
| rd_timeout_o | output | 16 | Read-timeout register |
| err_any | output | 1 | Any error bit of mask 0x2F is set |
| wr_no_resp | output | 1 | Write CRC failure classified as no answer |

## Verification
The bench fills the buffer to its limit and pushes once more. A design that let the extra word in would either overwrite a stored word or raise no bit 24, and either fault shows in the drained order or in the status value. It reads an empty buffer, and it accesses the port against the current direction; a wrong design would return stale data, move pointers or raise flags that should stay clear. It drives a clearing write and a setting event into the same cycle, where a write-priority design would lose the event. It also sends write CRC reports with codes 2, 1 and 0, and a design that ignored the code or acted on code 0 would show a wrong [10:9] field or a wrong `wr_no_resp`.

// File: rtl/sdbs_pkg.sv
package sdbs_pkg;

  typedef enum logic [2:0] {
    A_STAT  = 3'd0,
    A_BLEN  = 3'd1,
    A_BCNT  = 3'd2,
    A_RDTO  = 3'd3,
    A_DATA  = 3'd4,
    A_BYTES = 3'd5
  } sdbs_addr_e;

  localparam int B_RD_TO    = 0;
  localparam int B_RSP_TO   = 1;
  localparam int B_WCRC     = 2;
  localparam int B_RCRC     = 3;
  localparam int B_RSP_CRC  = 5;
  localparam int B_WR_RDY   = 6;
  localparam int B_RD_RDY   = 7;
  localparam int B_CODE_LO  = 9;
  localparam int B_RD_DONE  = 11;
  localparam int B_WR_DONE  = 12;
  localparam int B_OVF      = 24;
  localparam int B_UNF      = 25;

  localparam logic [31:0] ERR_SUMMARY = 32'h0000_002F;
  localparam logic [31:0] STICKY_BITS = 32'h0300_182F;
  localparam logic [1:0]  WCODE_NO_RESP = 2'd2;

endpackage

// File: rtl/sdbs_fifo.sv
module sdbs_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_req,
  input  logic [W-1:0] push_data,
  input  logic         pop_req,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CW-1:0] count, count_n;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign head    = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (push_ok) wr_ptr_n = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (pop_ok)  rd_ptr_n = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    if (push_ok && !pop_ok) count_n = count + 1'b1;
    else if (pop_ok && !push_ok) count_n = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  // R10
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req) |=> (count == $past(count)));

  // R3
  fifo_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !empty && !push_req) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/sdbs_status.sv
module sdbs_status
  import sdbs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] set_vec,
  input  logic        wcode_valid,
  input  logic [1:0]  wcode,
  input  logic        clr_we,
  input  logic [31:0] clr_vec,
  output logic [31:0] sticky,
  output logic [1:0]  code
);
  logic [31:0] sticky_n, set_all, clr_eff;
  logic [1:0]  code_n;
  logic        wcode_fail;

  assign wcode_fail = wcode_valid && (wcode != 2'd0);

  always_comb begin
    set_all         = set_vec;
    set_all[B_WCRC] = set_vec[B_WCRC] | wcode_fail;
    clr_eff         = clr_we ? clr_vec : 32'd0;
    sticky_n        = ((sticky & ~clr_eff) | set_all) & STICKY_BITS;
    code_n          = code;
    if (wcode_fail)           code_n = wcode;
    else if (clr_eff[B_WCRC]) code_n = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
      code   <= '0;
    end else begin
      sticky <= sticky_n;
      code   <= code_n;
    end
  end

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (set_vec == 32'd0) && !wcode_valid) |=>
      ((sticky & $past(clr_vec)) == 32'd0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 32'd0) |=>
      ((sticky & $past(set_vec & STICKY_BITS)) == $past(set_vec & STICKY_BITS)));

  // R7
  wcode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcode_valid && (wcode != 2'd0)) |=> ((code == $past(wcode)) && sticky[B_WCRC]));

endmodule

// File: rtl/sdbuf_stat_ctrl.sv
module sdbuf_stat_ctrl
  import sdbs_pkg::*;
#(
  parameter int              DEPTH   = 4,
  parameter int              BLEN_W  = 12,
  parameter int              BCNT_W  = 16,
  parameter int              TO_W    = 16,
  parameter logic [TO_W-1:0] TO_INIT = 16'h2DB4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dir_wr,
  input  logic              eng_push,
  input  logic [31:0]       eng_wdata,
  input  logic              eng_pop,
  output logic [31:0]       eng_rdata,
  output logic              eng_has_data,
  output logic              eng_has_space,
  input  logic              ev_rd_done,
  input  logic              ev_wr_done,
  input  logic              ev_rd_timeout,
  input  logic              ev_rd_crc,
  input  logic              ev_rsp_timeout,
  input  logic              ev_rsp_crc,
  input  logic              ev_wcrc_valid,
  input  logic [1:0]        ev_wcrc_code,
  output logic [BLEN_W-1:0] blk_len_o,
  output logic [BCNT_W-1:0] blk_cnt_o,
  output logic [TO_W-1:0]   rd_timeout_o,
  output logic              err_any,
  output logic              wr_no_resp
);
  localparam int PROD_W = BLEN_W + BCNT_W;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  sdbs_addr_e addr;
  assign addr = sdbs_addr_e'(reg_addr);

  logic host_dwr, host_drd;
  assign host_dwr = reg_wr && (addr == A_DATA);
  assign host_drd = reg_rd && (addr == A_DATA);

  // shared buffer, direction selects which side fills it
  logic        f_push, f_pop, f_full, f_empty;
  logic [31:0] f_pdata, f_head;
  assign f_push  = dir_wr ? host_dwr  : eng_push;
  assign f_pdata = dir_wr ? reg_wdata : eng_wdata;
  assign f_pop   = dir_wr ? eng_pop   : host_drd;

  sdbs_fifo #(.DEPTH(DEPTH), .W(32)) i_fifo (
    .clk(clk), .rst_n(rst_s_n),
    .push_req(f_push), .push_data(f_pdata), .pop_req(f_pop),
    .head(f_head), .full(f_full), .empty(f_empty)
  );

  assign eng_rdata     = f_head;
  assign eng_has_data  = !f_empty;
  assign eng_has_space = !f_full;

  // size and timeout registers
  logic [BLEN_W-1:0] blen, blen_n;
  logic [BCNT_W-1:0] bcnt, bcnt_n;
  logic [TO_W-1:0]   rdto, rdto_n;

  always_comb begin
    blen_n = blen;
    bcnt_n = bcnt;
    rdto_n = rdto;
    if (reg_wr && addr == A_BLEN) blen_n = reg_wdata[BLEN_W-1:0];
    if (reg_wr && addr == A_BCNT) bcnt_n = reg_wdata[BCNT_W-1:0];
    if (reg_wr && addr == A_RDTO) rdto_n = reg_wdata[TO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      blen <= '0;
      bcnt <= '0;
      rdto <= TO_INIT;
    end else begin
      blen <= blen_n;
      bcnt <= bcnt_n;
      rdto <= rdto_n;
    end
  end

  assign blk_len_o    = blen;
  assign blk_cnt_o    = bcnt;
  assign rd_timeout_o = rdto;

  logic [PROD_W-1:0] xfer_bytes;
  assign xfer_bytes = PROD_W'(blen) * PROD_W'(bcnt);

  // status
  logic [31:0] set_vec, sticky, stat_word;
  logic [1:0]  wcode;
  logic        ovf_ev, unf_ev;

  assign ovf_ev = host_dwr && dir_wr && f_full;
  assign unf_ev = host_drd && !dir_wr && f_empty;

  always_comb begin
    set_vec              = '0;
    set_vec[B_RD_TO]     = ev_rd_timeout;
    set_vec[B_RSP_TO]    = ev_rsp_timeout;
    set_vec[B_RCRC]      = ev_rd_crc;
    set_vec[B_RSP_CRC]   = ev_rsp_crc;
    set_vec[B_RD_DONE]   = ev_rd_done;
    set_vec[B_WR_DONE]   = ev_wr_done;
    set_vec[B_OVF]       = ovf_ev;
    set_vec[B_UNF]       = unf_ev;
  end

  sdbs_status i_status (
    .clk(clk), .rst_n(rst_s_n),
    .set_vec(set_vec), .wcode_valid(ev_wcrc_valid), .wcode(ev_wcrc_code),
    .clr_we(reg_wr && addr == A_STAT), .clr_vec(reg_wdata),
    .sticky(sticky), .code(wcode)
  );

  always_comb begin
    stat_word                        = sticky;
    stat_word[B_CODE_LO+1:B_CODE_LO] = wcode;
    stat_word[B_RD_RDY]              = !f_empty;
    stat_word[B_WR_RDY]              = !f_full;
  end

  assign err_any    = |(stat_word & ERR_SUMMARY);
  assign wr_no_resp = sticky[B_WCRC] && (wcode == WCODE_NO_RESP);

  always_comb begin
    case (addr)
      A_STAT:  reg_rdata = stat_word;
      A_BLEN:  reg_rdata = 32'(blen);
      A_BCNT:  reg_rdata = 32'(bcnt);
      A_RDTO:  reg_rdata = 32'(rdto);
      A_DATA:  reg_rdata = (!dir_wr && !f_empty) ? f_head : 32'd0;
      A_BYTES: reg_rdata = 32'(xfer_bytes);
      default: reg_rdata = 32'd0;
    endcase
  end

  // R10
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (host_drd && !dir_wr && f_empty) |=> stat_word[B_UNF]);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_wr && addr == A_STAT && (reg_wdata & ERR_SUMMARY) == ERR_SUMMARY &&
     !ev_rd_timeout && !ev_rsp_timeout && !ev_rd_crc && !ev_rsp_crc &&
     !ev_wcrc_valid) |=> !err_any);

endmodule

// File: tb/test_sdbuf_stat_ctrl.sv
module test_sdbuf_stat_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        dir_wr, eng_push, eng_pop;
  logic [31:0] eng_wdata, eng_rdata;
  logic        eng_has_data, eng_has_space;
  logic [6:0]  evs;
  logic [1:0]  wcode;
  logic [11:0] blk_len_o;
  logic [15:0] blk_cnt_o, rd_timeout_o;
  logic        err_any, wr_no_resp;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  sdbuf_stat_ctrl i_sdbuf_stat_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dir_wr(dir_wr), .eng_push(eng_push), .eng_wdata(eng_wdata),
    .eng_pop(eng_pop), .eng_rdata(eng_rdata),
    .eng_has_data(eng_has_data), .eng_has_space(eng_has_space),
    .ev_rd_done(evs[0]), .ev_wr_done(evs[1]), .ev_rd_timeout(evs[2]),
    .ev_rd_crc(evs[3]), .ev_rsp_timeout(evs[4]), .ev_rsp_crc(evs[5]),
    .ev_wcrc_valid(evs[6]), .ev_wcrc_code(wcode),
    .blk_len_o(blk_len_o), .blk_cnt_o(blk_cnt_o), .rd_timeout_o(rd_timeout_o),
    .err_any(err_any), .wr_no_resp(wr_no_resp)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (reg_rd) begin
      if (exp_q.size() == 0) chk("unexpected read", reg_rdata, 32'hDEAD_BEEF);
      else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic push_word(logic [31:0] w);
    @(posedge clk); #1;
    eng_push = 1'b1; eng_wdata = w;
    @(posedge clk); #1;
    eng_push = 1'b0;
  endtask

  task automatic pop_check(logic [31:0] exp, string tag);
    @(negedge clk);
    chk(tag, eng_rdata, exp);
    @(posedge clk); #1;
    eng_pop = 1'b1;
    @(posedge clk); #1;
    eng_pop = 1'b0;
  endtask

  task automatic pulse_ev(logic [6:0] v, logic [1:0] c);
    @(posedge clk); #1;
    evs = v; wcode = c;
    @(posedge clk); #1;
    evs = '0; wcode = '0;
  endtask

  task automatic flag_check(string tag, logic act, logic exp);
    @(negedge clk);
    chk(tag, 32'(act), 32'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    dir_wr = 1'b1; eng_push = 0; eng_pop = 0; eng_wdata = 0; evs = '0; wcode = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    reg_read(3'd0, 32'h40, "R1 status after reset");
    reg_read(3'd3, 32'h2DB4, "R1 read timeout after reset");
    reg_read(3'd1, 32'h0, "R1 block length after reset");
    reg_read(3'd2, 32'h0, "R1 block count after reset");

    // R2 sizes and byte total
    reg_write(3'd1, 32'd512);
    reg_write(3'd2, 32'd3);
    reg_read(3'd1, 32'd512, "R2 block length readback");
    reg_read(3'd5, 32'd1536, "R2 byte total 3x512");
    reg_write(3'd1, 32'd4);
    reg_write(3'd2, 32'hFFFF);
    reg_read(3'd5, 32'h3FFFC, "R2 byte total 65535x4");

    // R3 / R4 / R10 write direction
    dir_wr = 1'b1;
    reg_write(3'd4, 32'hA000_0001);
    reg_read(3'd0, 32'hC0, "R4 one word held");
    reg_write(3'd4, 32'hB000_0002);
    reg_write(3'd4, 32'hC000_0003);
    reg_write(3'd4, 32'hD000_0004);
    reg_read(3'd0, 32'h80, "R4 buffer full");
    reg_write(3'd4, 32'hE000_0005);
    reg_read(3'd0, 32'h0100_0080, "R10 overflow flag");
    pop_check(32'hA000_0001, "R3 write order word 0");
    pop_check(32'hB000_0002, "R3 write order word 1");
    pop_check(32'hC000_0003, "R3 write order word 2");
    pop_check(32'hD000_0004, "R10 dropped word not stored");
    reg_read(3'd0, 32'h0100_0040, "R4 drained");
    reg_write(3'd0, 32'h0100_0000);
    reg_read(3'd0, 32'h40, "R8 overflow cleared");

    // R11 read of data port in write direction
    reg_read(3'd4, 32'h0, "R11 data read in write direction");
    reg_read(3'd0, 32'h40, "R11 no underrun in write direction");

    // R10 underrun in read direction
    dir_wr = 1'b0;
    reg_read(3'd4, 32'h0, "R10 underrun returns zero");
    reg_read(3'd0, 32'h0200_0040, "R10 underrun flag");
    reg_write(3'd0, 32'h0200_0000);
    reg_read(3'd0, 32'h40, "R8 underrun cleared");

    // R11 write of data port in read direction
    reg_write(3'd4, 32'h5555_5555);
    reg_read(3'd0, 32'h40, "R11 data write in read direction ignored");

    // R3 read direction order
    push_word(32'h1111_1111);
    reg_read(3'd0, 32'hC0, "R4 engine word held");
    push_word(32'h2222_2222);
    push_word(32'h3333_3333);
    reg_read(3'd4, 32'h1111_1111, "R3 read order word 0");
    reg_read(3'd4, 32'h2222_2222, "R3 read order word 1");
    reg_read(3'd4, 32'h3333_3333, "R3 read order word 2");
    reg_read(3'd0, 32'h40, "R3 buffer empty after reads");

    // R4 ready bits not writable
    reg_write(3'd0, 32'hC0);
    reg_read(3'd0, 32'h40, "R4 ready bits ignore writes");

    // R5 completion bits, R9 no error
    pulse_ev(7'b000_0001, 2'd0);
    pulse_ev(7'b000_0010, 2'd0);
    reg_read(3'd0, 32'h1840, "R5 read and write done");
    flag_check("R9 done bits not errors", err_any, 1'b0);
    reg_write(3'd0, 32'h0);
    reg_read(3'd0, 32'h1840, "R8 writing zero keeps bits");
    reg_write(3'd0, 32'h1800);
    reg_read(3'd0, 32'h40, "R8 done bits cleared");

    // R6 / R9 error bits
    pulse_ev(7'b000_0100, 2'd0);
    reg_read(3'd0, 32'h41, "R6 read timeout bit");
    flag_check("R9 err_any on read timeout", err_any, 1'b1);
    reg_write(3'd0, 32'h1);
    pulse_ev(7'b011_1000, 2'd0);
    reg_read(3'd0, 32'h6A, "R6 crc and response bits");
    flag_check("R9 err_any on crc", err_any, 1'b1);
    reg_write(3'd0, 32'h6A);
    reg_read(3'd0, 32'h40, "R8 write-back clears observed");
    flag_check("R9 err_any cleared", err_any, 1'b0);

    // R7 write crc code
    pulse_ev(7'b100_0000, 2'd2);
    reg_read(3'd0, 32'h444, "R7 code 2 latched");
    flag_check("R7 no response flag", wr_no_resp, 1'b1);
    flag_check("R9 err_any on write crc", err_any, 1'b1);
    pulse_ev(7'b100_0000, 2'd1);
    reg_read(3'd0, 32'h244, "R7 code 1 latched");
    flag_check("R7 code 1 not no-response", wr_no_resp, 1'b0);
    reg_write(3'd0, 32'h4);
    reg_read(3'd0, 32'h40, "R7 clear bit 2 clears code");
    pulse_ev(7'b100_0000, 2'd0);
    reg_read(3'd0, 32'h40, "R7 code 0 ignored");

    // R8 set wins over same-cycle clear
    pulse_ev(7'b000_0001, 2'd0);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h800; evs = 7'b000_0001;
    @(posedge clk); #1;
    reg_wr = 1'b0; evs = '0;
    reg_read(3'd0, 32'h840, "R8 set wins over clear");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) chk("R3 pending reads", 32'(exp_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule